// File: doc/BRIEF.md
# Transfer Snoop Checksum Unit

This block sits beside a DMA engine and watches the data words that engine moves. When a word belongs to the channel picked in the control register, and that channel has its own snoop permission raised, the block folds the word into a 32-bit accumulator. The folding rule is picked by an operation code. It can be a CRC32 or a CRC16-CCITT, each in a most-significant-bit-first form or a reflected least-significant-bit-first form. It can also be a one-bit parity fold or a wrapping 32-bit sum.

Software sets up the unit through a small register port. The accumulator can be seeded with a plain write, or changed in place through three atomic aliases that XOR, set or clear bits. When the accumulator is read, it can be bit-reversed, inverted, or both. This changes only what the read returns and never the stored value. A typical use is to seed the accumulator, let a channel stream a buffer into a write sink, and then read back the checksum or sum.

Top module: `dsniff_top`

## Requirements
- R1: After reset, the control register reads 0x000 and the accumulator reads 0x00000000.
- R2: The control register sits at byte offset 0x000. Its fields are enable at bit 0, channel select at bits 4:1, operation code at bits 8:5, read bit-reverse at bit 10 and read invert at bit 11. Bits 9 and 31:12 always read 0.
- R3: The accumulator changes on a transfer only when all of these hold in the same cycle: xfer_valid is 1, xfer_snoop_en is 1, the control enable is 1, and xfer_chan equals the channel select.
- R4: Op 0x0 is CRC32 with polynomial 0x04C11DB7, data taken bit 31 first. Op 0x1 is the reflected form with polynomial 0xEDB88320, shifting right, data taken bit 0 first. Neither form applies a final XOR.
- R5: Op 0x2 is CRC16 with polynomial 0x1021 on accumulator bits 15:0, data bit 31 first. Op 0x3 is the reflected form with polynomial 0x8408, data bit 0 first. In both forms the upper 16 bits become 0.
- R6: Op 0xE sets the accumulator to 31 zero bits followed by old bit 0 XOR the parity of the data word.
- R7: Op 0xF adds the data word to the accumulator modulo 2^32.
- R8: Op codes 0x4 to 0xD leave the accumulator unchanged.
- R9: The accumulator is at byte offset 0x004. Address bits 13:12 pick the write action: 00 writes the value, 01 XORs it in, 10 sets bits, 11 clears bits. Clearing all bits, then setting 0x1, then XORing 0x7 gives 6.
- R10: A read of the accumulator returns the stored value, bit-reversed if control bit 10 is set and then inverted if control bit 11 is set. The stored value itself is not changed.
- R11: If a register write to the accumulator and a qualifying transfer arrive in the same cycle, the register write decides the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register byte address; bits 13:12 select the alias |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| xfer_valid | input | 1 | A DMA data word is on xfer_data this cycle |
| xfer_chan | input | 4 | Channel that moved the word |
| xfer_snoop_en | input | 1 | That channel's own snoop permission |
| xfer_data | input | 32 | Transferred data word |

## Verification
The bench targets words that must be ignored: a wrong channel, a channel without snoop permission, the unit disabled, and an undefined op code. A design that qualified transfers too loosely would change the accumulator in each of these cases. The bench also checks carry wrap in the sum mode, which a design with a narrow adder would lose, and it checks bit order in the reflected CRCs, which a design that mixed up shift direction would get wrong. Finally, it checks a register write and a transfer in the same cycle, and confirms that the read view leaves the stored value intact. A design that wrote the view back into the accumulator would corrupt later results.

// File: rtl/dsniff_pkg.sv
// Shared types and constants for the transfer snoop checksum unit.
// Assumes a 32-bit data path and 4-bit channel identifiers.
package dsniff_pkg;
    localparam int DW  = 32;
    localparam int CHW = 4;

    typedef enum logic [3:0] {
        OP_CRC32   = 4'h0,
        OP_CRC32R  = 4'h1,
        OP_CRC16   = 4'h2,
        OP_CRC16R  = 4'h3,
        OP_PARITY  = 4'hE,
        OP_SUM     = 4'hF
    } sniff_op_e;

    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_XOR   = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLR   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic             inv;
        logic             rev;
        logic [3:0]       op;
        logic [CHW-1:0]   chan;
        logic             en;
    } sniff_cfg_t;

    localparam logic [31:0] POLY32  = 32'h04C11DB7;
    localparam logic [31:0] POLY32R = 32'hEDB88320;
    localparam logic [15:0] POLY16  = 16'h1021;
    localparam logic [15:0] POLY16R = 16'h8408;
endpackage

// File: rtl/dsniff_bitrev.sv
// Mirrors the bit order of a W-bit vector. Purely combinational.
module dsniff_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // one wire per bit, mirrored position
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/dsniff_engine.sv
// Computes the next accumulator value for one data word under the
// selected operation. Combinational. Assumes DW is 32; upd_ok is low
// for op codes without a defined rule.
module dsniff_engine
    import dsniff_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] data,
    output logic [W-1:0] nxt,
    output logic         upd_ok
);
    localparam int HW = W / 2;

    logic [W-1:0]  c32;
    logic [HW-1:0] c16;
    logic          fb;

    // folds the word according to the op code
    always_comb begin
        nxt    = acc;
        upd_ok = 1'b1;
        c32    = acc;
        c16    = acc[HW-1:0];
        fb     = 1'b0;
        case (op)
            OP_CRC32: begin
                for (int i = W-1; i >= 0; i--) begin
                    fb  = c32[W-1] ^ data[i];
                    c32 = {c32[W-2:0], 1'b0} ^ (fb ? POLY32 : '0);
                end
                nxt = c32;
            end
            OP_CRC32R: begin
                for (int i = 0; i < W; i++) begin
                    fb  = c32[0] ^ data[i];
                    c32 = {1'b0, c32[W-1:1]} ^ (fb ? POLY32R : '0);
                end
                nxt = c32;
            end
            OP_CRC16: begin
                for (int i = W-1; i >= 0; i--) begin
                    fb  = c16[HW-1] ^ data[i];
                    c16 = {c16[HW-2:0], 1'b0} ^ (fb ? POLY16 : '0);
                end
                nxt = {{HW{1'b0}}, c16};
            end
            OP_CRC16R: begin
                for (int i = 0; i < W; i++) begin
                    fb  = c16[0] ^ data[i];
                    c16 = {1'b0, c16[HW-1:1]} ^ (fb ? POLY16R : '0);
                end
                nxt = {{HW{1'b0}}, c16};
            end
            OP_PARITY: nxt = {{(W-1){1'b0}}, acc[0] ^ (^data)};
            OP_SUM:    nxt = acc + data;
            default:   upd_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsniff_regs.sv
// Holds the control register and the accumulator. Register writes to
// the accumulator take priority over a same-cycle transfer update.
// Assumes byte addresses with alias selection in bits 13:12.
module dsniff_regs
    import dsniff_pkg::*;
#(
    parameter int AW = 14,
    parameter int W  = DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    input  logic          hit,
    input  logic          upd_ok,
    input  logic [W-1:0]  eng_nxt,
    output sniff_cfg_t    cfg_q,
    output logic [W-1:0]  res_q
);
    localparam int          ALIAS_LSB = 12;
    localparam logic [11:0] CTRL_OFS  = 12'h000;
    localparam logic [11:0] RES_OFS   = 12'h004;

    acc_kind_e  kind;
    logic       ctrl_sel, res_sel;
    logic [W-1:0] wr_val;

    // address decode of the register port
    always_comb begin
        kind     = acc_kind_e'(reg_addr[ALIAS_LSB+1:ALIAS_LSB]);
        ctrl_sel = reg_wr && (reg_addr[11:0] == CTRL_OFS) && (kind == ACC_PLAIN);
        res_sel  = reg_wr && (reg_addr[11:0] == RES_OFS);
    end

    // value produced by a write through one of the accumulator aliases
    always_comb begin
        case (kind)
            ACC_XOR: wr_val = res_q ^ reg_wdata;
            ACC_SET: wr_val = res_q | reg_wdata;
            ACC_CLR: wr_val = res_q & ~reg_wdata;
            default: wr_val = reg_wdata;
        endcase
    end

    // control register storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (ctrl_sel)
            cfg_q <= '{inv:  reg_wdata[11], rev: reg_wdata[10],
                       op:   reg_wdata[8:5], chan: reg_wdata[4:1],
                       en:   reg_wdata[0]};
    end

    // accumulator storage, register write beats transfer update
    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else if (res_sel)
            res_q <= wr_val;
        else if (hit && upd_ok)
            res_q <= eng_nxt;
    end
endmodule

// File: rtl/dsniff_top.sv
// Transfer snoop checksum unit: qualifies snooped DMA words, folds
// them into an accumulator and serves a register read/write port.
// Assumes one snooped word per cycle at most.
module dsniff_top
    import dsniff_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          xfer_valid,
    input  logic [3:0]    xfer_chan,
    input  logic          xfer_snoop_en,
    input  logic [31:0]   xfer_data
);
    sniff_cfg_t  cfg_q;
    logic [31:0] res_q, eng_nxt, res_rev, res_view;
    logic        upd_ok, hit;

    // transfer qualification against the selected channel
    always_comb hit = xfer_valid && xfer_snoop_en && cfg_q.en && (xfer_chan == cfg_q.chan);

    dsniff_engine #(.W(32)) u_engine (
        .op     (cfg_q.op),
        .acc    (res_q),
        .data   (xfer_data),
        .nxt    (eng_nxt),
        .upd_ok (upd_ok)
    );

    dsniff_regs #(.AW(AW), .W(32)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hit       (hit),
        .upd_ok    (upd_ok),
        .eng_nxt   (eng_nxt),
        .cfg_q     (cfg_q),
        .res_q     (res_q)
    );

    dsniff_bitrev #(.W(32)) u_rev (
        .din  (res_q),
        .dout (res_rev)
    );

    // read view: optional mirror, then optional invert
    always_comb begin
        res_view = cfg_q.rev ? res_rev : res_q;
        if (cfg_q.inv) res_view = ~res_view;
    end

    // read data mux by offset within the window
    always_comb begin
        case (reg_addr[11:0])
            12'h000: reg_rdata = {20'h0, cfg_q.inv, cfg_q.rev, 1'b0, cfg_q.op, cfg_q.chan, cfg_q.en};
            12'h004: reg_rdata = res_view;
            default: reg_rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/dsniff_chk.sv
// Property checker for dsniff_top, attached through bind.
module dsniff_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [13:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        hit,
    input logic [3:0]  op,
    input logic        rev,
    input logic        inv,
    input logic [31:0] res_q,
    input logic [31:0] xfer_data
);
    logic res_w;
    always_comb res_w = reg_wr && (reg_addr[11:0] == 12'h004);

    // R3: no qualifying word and no write keeps the accumulator
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !res_w) |=> res_q == $past(res_q));

    // R9 / R11: plain write sets the value even during a transfer
    a_r9_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (res_w && reg_addr[13:12] == 2'b00) |=> res_q == $past(reg_wdata));

    // R9: XOR alias
    a_r9_xor: assert property (@(posedge clk) disable iff (!rst_n)
        (res_w && reg_addr[13:12] == 2'b01) |=> res_q == ($past(res_q) ^ $past(reg_wdata)));

    // R9: set alias
    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        (res_w && reg_addr[13:12] == 2'b10) |=> res_q == ($past(res_q) | $past(reg_wdata)));

    // R9: clear alias
    a_r9_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (res_w && reg_addr[13:12] == 2'b11) |=> res_q == ($past(res_q) & ~$past(reg_wdata)));

    // R7: sum mode adds the word
    a_r7_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !res_w && op == 4'hF) |=> res_q == $past(res_q) + $past(xfer_data));

    // R8: undefined op codes hold
    a_r8_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_w && op >= 4'h4 && op <= 4'hD) |=> res_q == $past(res_q));

    // R10: with no view options the read returns the stored value
    a_r10_view: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[11:0] == 12'h004 && !rev && !inv) |-> reg_rdata == res_q);
endmodule

bind dsniff_top dsniff_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hit       (hit),
    .op        (cfg_q.op),
    .rev       (cfg_q.rev),
    .inv       (cfg_q.inv),
    .res_q     (res_q),
    .xfer_data (xfer_data)
);

// File: tb/dsniff_top_tb.sv
`timescale 1ns/1ps
module dsniff_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [13:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_valid = 1'b0;
    logic [3:0]  xfer_chan = '0;
    logic        xfer_snoop_en = 1'b0;
    logic [31:0] xfer_data = '0;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dsniff_top u_dut (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] seed;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 32'hFFFFFFFF, 32'h12345678},   // R4
        '{4'h0, 32'h00000000, 32'h80000001},   // R4
        '{4'h1, 32'hFFFFFFFF, 32'h12345678},   // R4
        '{4'h1, 32'h00000000, 32'h00000001},   // R4
        '{4'h2, 32'hABCDFFFF, 32'hDEADBEEF},   // R5
        '{4'h3, 32'h1234FFFF, 32'hCAFEF00D},   // R5
        '{4'hE, 32'hFFFFFFFE, 32'h00000007},   // R6
        '{4'hE, 32'h00000001, 32'h00000003},   // R6
        '{4'hF, 32'hFFFFFFF0, 32'h00000025},   // R7 wrap
        '{4'h7, 32'h5A5A5A5A, 32'h11111111}    // R8
    };

    // reference from the requirement text
    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] c;
        logic [15:0] h;
        c = a; h = a[15:0];
        case (op)
            4'h0: begin for (int i = 31; i >= 0; i--) c = (c[31] ^ d[i]) ? ((c << 1) ^ 32'h04C11DB7) : (c << 1); return c; end
            4'h1: begin for (int i = 0; i < 32; i++) c = (c[0] ^ d[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1); return c; end
            4'h2: begin for (int i = 31; i >= 0; i--) h = (h[15] ^ d[i]) ? ((h << 1) ^ 16'h1021) : (h << 1); return {16'h0, h}; end
            4'h3: begin for (int i = 0; i < 32; i++) h = (h[0] ^ d[i]) ? ((h >> 1) ^ 16'h8408) : (h >> 1); return {16'h0, h}; end
            4'hE: return {31'h0, a[0] ^ (^d)};
            4'hF: return a + d;
            default: return a;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic xfer(input logic [3:0] ch, input logic se, input logic [31:0] d);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_chan = ch; xfer_snoop_en = se; xfer_data = d;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input logic [3:0] op, input logic [3:0] ch);
        return {20'h0, 2'b00, 1'b0, op, ch, 1'b1};
    endfunction

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(14'h000, v); check("R1 ctrl", v, 32'h0);
        rd(14'h004, v); check("R1 acc", v, 32'h0);

        // R2: field readback, bit 9 and high bits dropped
        wr(14'h000, 32'hFFFF_FFFF);
        rd(14'h000, v); check("R2 ctrl mask", v, 32'h0000_0DFF);

        // vector table, channel 3
        foreach (VECS[i]) begin
            wr(14'h000, ctl(VECS[i].op, 4'd3));
            wr(14'h004, VECS[i].seed);
            xfer(4'd3, 1'b1, VECS[i].data);
            rd(14'h004, v);
            check($sformatf("R4-8 vec%0d op%0h", i, VECS[i].op), v, model(VECS[i].op, VECS[i].seed, VECS[i].data));
        end

        // R9: seed sequence gives 6, then sum mode R7
        wr(14'h000, ctl(4'hF, 4'd0));
        wr(14'h004, 32'h1234_5678);
        wr(14'h3004, 32'hFFFF_FFFF);
        wr(14'h2004, 32'h0000_0001);
        wr(14'h1004, 32'h0000_0007);
        rd(14'h004, v); check("R9 seed", v, 32'd6);
        xfer(4'd0, 1'b1, 32'd20);
        xfer(4'd0, 1'b1, 32'hFFFF_FFF6);
        xfer(4'd0, 1'b1, 32'd5);
        rd(14'h004, v); check("R7 sum", v, 32'd21);

        // R3: ignored transfers
        xfer(4'd1, 1'b1, 32'd100);
        rd(14'h004, v); check("R3 wrong chan", v, 32'd21);
        xfer(4'd0, 1'b0, 32'd100);
        rd(14'h004, v); check("R3 snoop off", v, 32'd21);
        wr(14'h000, {20'h0, 2'b00, 1'b0, 4'hF, 4'd0, 1'b0});
        xfer(4'd0, 1'b1, 32'd100);
        rd(14'h004, v); check("R3 disabled", v, 32'd21);

        // R11: write wins over same-cycle transfer
        wr(14'h000, ctl(4'hF, 4'd0));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 14'h004; reg_wdata = 32'h55;
        xfer_valid = 1'b1; xfer_chan = 4'd0; xfer_snoop_en = 1'b1; xfer_data = 32'd9;
        @(negedge clk);
        reg_wr = 1'b0; xfer_valid = 1'b0;
        rd(14'h004, v); check("R11 write wins", v, 32'h55);

        // R10: read view options, storage untouched
        wr(14'h004, 32'h0000_0003);
        wr(14'h000, {20'h0, 2'b01, 1'b0, 4'h7, 4'd0, 1'b1});
        rd(14'h004, v); check("R10 rev", v, 32'hC000_0000);
        wr(14'h000, {20'h0, 2'b10, 1'b0, 4'h7, 4'd0, 1'b1});
        rd(14'h004, v); check("R10 inv", v, 32'hFFFF_FFFC);
        wr(14'h000, {20'h0, 2'b11, 1'b0, 4'h7, 4'd0, 1'b1});
        rd(14'h004, v); check("R10 rev+inv", v, 32'h3FFF_FFFF);
        wr(14'h000, {20'h0, 2'b00, 1'b0, 4'h7, 4'd0, 1'b1});
        rd(14'h004, v); check("R10 stored intact", v, 32'h0000_0003);

        // R8: undefined op ignores a qualifying word
        xfer(4'd0, 1'b1, 32'hFFFF);
        rd(14'h004, v); check("R8 undefined op", v, 32'h0000_0003);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule